// File: doc/BRIEF.md
# Parallel Converter Read Sequencer

This block runs a successive-approximation converter that has a parallel result bus. It is the host side of that link. It issues a conversion-start pulse in one of two polarities and watches the converter's status line for completion. It then drops chip-select and read together, takes the result word from the bus into an output register, and pulses a valid strobe. Before the next start it holds a quiet gap of whole clock cycles, so that bus activity has died away when sampling begins.

Conversions run one at a time. With free-run held high, each new conversion starts as soon as the quiet gap ends. With free-run low, the sequencer parks in its idle state until a trigger arrives. The status line and the data bus are taken to be synchronous to `clk`. Any timing margins finer than a clock cycle are the board's concern.

The sequencer has five named states:
- `ST_IDLE`: the start line is parked, and the polarity select is sampled here.
- `ST_START`: the start pulse is driven.
- `ST_WAIT`: the status line is watched for completion.
- `ST_READ`: chip-select and read are low.
- `ST_QUIET`: the gap before the next start.

It has seven named transitions:
- `IDLE->START` on a trigger or on free-run.
- `START->WAIT` when the pulse timer ends.
- `WAIT->READ` on completion.
- `READ->QUIET` when the read timer ends, which also captures the result.
- `QUIET->START` when the gap ends with free-run high.
- `QUIET->IDLE` when the gap ends with free-run low.
- `WAIT->WAIT` and the other timed self-loops while their counters run.

Top module: `adc_rd_ctrl`

## Requirements
- R1: When `mode_busy` has been sampled as 0 (strobe polarity), `convst` rests at 1 and goes to 0 for exactly `START_CYC` cycles for each conversion. The conversion begins when the line returns to 1.
- R2: When `mode_busy` has been sampled as 1 (busy polarity), `convst` rests at 0 and goes to 1 for exactly `START_CYC` cycles for each conversion. The conversion begins on the rising edge.
- R3: Completion detection depends on the polarity.
  - In strobe polarity, completion is `busy_eoc` sampled at 0 while waiting.
  - In busy polarity, completion is `busy_eoc` sampled at 0 while waiting, after it has been sampled at 1 earlier in the same wait.
  - In both polarities, `cs_n` and `rd_n` go low in the cycle after the edge that sees completion.
- R4: `cs_n` and `rd_n` are both 0 for exactly `RD_CYC` consecutive cycles per conversion. They are never low apart from one another, and never low outside that read window.
- R5: `result` takes `data_in` at the clock edge that ends the last read cycle. At all other times it holds its value.
- R6: `result_valid` is 1 for exactly one cycle per conversion: the first cycle after `rd_n` returns to 1.
- R7: After `rd_n` returns to 1, `convst` stays at its resting level for `QUIET_CYC` cycles. `QUIET_CYC` is `QUIET_PS/CLK_PERIOD_PS` rounded up, with a minimum of 1. The defaults give 30 cycles, which covers 150 ns at 200 MHz.
- R8: If `free_run` is 1 when the quiet gap ends, the next start pulse begins in the very next cycle. If it is 0, the sequencer returns to idle.
- R9: While idle, a cycle with `trigger` or `free_run` at 1 puts the start pulse on `convst` in the next cycle. A `trigger` at any other time has no effect.
- R10: `mode_busy` is sampled only while idle. A change during a conversion does not alter that conversion's start or completion polarity.
- R11: After reset, `convst`=1, `cs_n`=1, `rd_n`=1, `result`=0 and `result_valid`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| trigger | input | 1 | Request one conversion while idle |
| free_run | input | 1 | Start conversions back to back |
| mode_busy | input | 1 | 0: strobe polarity, 1: busy polarity |
| busy_eoc | input | 1 | Converter status line |
| data_in | input | DATA_W | Converter result bus |
| convst | output | 1 | Conversion start line |
| cs_n | output | 1 | Chip select, active low |
| rd_n | output | 1 | Read strobe, active low |
| result | output | DATA_W | Captured result word |
| result_valid | output | 1 | One-cycle pulse on a new result |

## Verification
The bench builds the block with `START_CYC=2`, `RD_CYC=3` and `QUIET_PS=20000`, which gives a 4-cycle quiet gap. A multi-cycle start pulse tests the pulse-width counting in both polarities. A three-cycle read places the capture edge away from the first read cycle. The short gap lets many back-to-back free-run conversions in both polarities fit into a short run. A change of polarity and a stray trigger are both injected in the middle of a conversion, to show that they are ignored.

// File: rtl/adc_rd_pkg.sv
package adc_rd_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_START,
        ST_WAIT,
        ST_READ,
        ST_QUIET
    } ctl_state_t;

endpackage

// File: rtl/adc_rd_timer.sv
module adc_rd_timer #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic         zero
);
    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);

    // R7: a running interval shortens by exactly one each cycle
    assert_timer_step_R7: assert property (@(posedge clk) disable iff (rst)
        (!load && !zero) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/adc_rd_done_det.sv
module adc_rd_done_det (
    input  logic clk,
    input  logic rst,
    input  logic arm,
    input  logic mode_busy,
    input  logic status,
    output logic done
);
    logic seen_high_q;

    always_ff @(posedge clk) begin
        if (rst || !arm) begin
            seen_high_q <= 1'b0;
        end else if (status) begin
            seen_high_q <= 1'b1;
        end
    end

    always_comb begin
        if (mode_busy) begin
            done = arm && seen_high_q && !status;
        end else begin
            done = arm && !status;
        end
    end

endmodule

// File: rtl/adc_rd_ctrl.sv
module adc_rd_ctrl
    import adc_rd_pkg::*;
#(
    parameter int DATA_W        = 14,
    parameter int START_CYC     = 1,
    parameter int RD_CYC        = 2,
    parameter int CLK_PERIOD_PS = 5000,
    parameter int QUIET_PS      = 150000
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              trigger,
    input  logic              free_run,
    input  logic              mode_busy,
    input  logic              busy_eoc,
    input  logic [DATA_W-1:0] data_in,
    output logic              convst,
    output logic              cs_n,
    output logic              rd_n,
    output logic [DATA_W-1:0] result,
    output logic              result_valid
);
    localparam int QUIET_RAW = (QUIET_PS + CLK_PERIOD_PS - 1) / CLK_PERIOD_PS;
    localparam int QUIET_CYC = (QUIET_RAW < 1) ? 1 : QUIET_RAW;
    localparam int MAX_A     = (START_CYC > RD_CYC) ? START_CYC : RD_CYC;
    localparam int MAX_CYC   = (MAX_A > QUIET_CYC) ? MAX_A : QUIET_CYC;
    localparam int TMR_W     = $clog2(MAX_CYC + 1);
    localparam logic [TMR_W-1:0] START_LD = TMR_W'(START_CYC - 1);
    localparam logic [TMR_W-1:0] READ_LD  = TMR_W'(RD_CYC - 1);
    localparam logic [TMR_W-1:0] QUIET_LD = TMR_W'(QUIET_CYC - 1);

    ctl_state_t       state_q, state_nx;
    logic             mode_q;
    logic             tmr_load;
    logic [TMR_W-1:0] tmr_val;
    logic             tmr_zero;
    logic             conv_done;

    adc_rd_timer #(.W(TMR_W)) u_timer (
        .clk      (clk),
        .rst      (rst),
        .load     (tmr_load),
        .load_val (tmr_val),
        .zero     (tmr_zero)
    );

    adc_rd_done_det u_done (
        .clk       (clk),
        .rst       (rst),
        .arm       (state_q == ST_WAIT),
        .mode_busy (mode_q),
        .status    (busy_eoc),
        .done      (conv_done)
    );

    // State register, plus the polarity sampled while idle
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            mode_q  <= 1'b0;
        end else begin
            state_q <= state_nx;
            if (state_q == ST_IDLE) begin
                mode_q <= mode_busy;
            end
        end
    end

    // Transitions and interval loading
    always_comb begin
        state_nx = state_q;
        tmr_load = 1'b0;
        tmr_val  = START_LD;
        unique case (state_q)
            ST_IDLE: begin
                if (trigger || free_run) begin
                    state_nx = ST_START;
                    tmr_load = 1'b1;
                    tmr_val  = START_LD;
                end
            end
            ST_START: begin
                if (tmr_zero) begin
                    state_nx = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (conv_done) begin
                    state_nx = ST_READ;
                    tmr_load = 1'b1;
                    tmr_val  = READ_LD;
                end
            end
            ST_READ: begin
                if (tmr_zero) begin
                    state_nx = ST_QUIET;
                    tmr_load = 1'b1;
                    tmr_val  = QUIET_LD;
                end
            end
            ST_QUIET: begin
                if (tmr_zero) begin
                    if (free_run) begin
                        state_nx = ST_START;
                        tmr_load = 1'b1;
                        tmr_val  = START_LD;
                    end else begin
                        state_nx = ST_IDLE;
                    end
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    // Pin levels decoded from the state
    always_comb begin
        convst = mode_q ? (state_q == ST_START) : (state_q != ST_START);
        cs_n   = (state_q != ST_READ);
        rd_n   = (state_q != ST_READ);
    end

    // Result capture on the final read cycle
    always_ff @(posedge clk) begin
        if (rst) begin
            result       <= '0;
            result_valid <= 1'b0;
        end else begin
            result_valid <= 1'b0;
            if (state_q == ST_READ && tmr_zero) begin
                result       <= data_in;
                result_valid <= 1'b1;
            end
        end
    end

    // R3: completion seen while waiting opens the read window next cycle
    assert_read_follows_done_R3: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_WAIT && conv_done) |=> (!rd_n && !cs_n));

    // R5: the result word changes only together with a valid pulse
    assert_result_hold_R5: assert property (@(posedge clk) disable iff (rst)
        !result_valid |-> $stable(result));

    // R6: the valid strobe lasts one cycle
    assert_valid_single_R6: assert property (@(posedge clk) disable iff (rst)
        result_valid |=> !result_valid);

    // R6: the valid strobe comes right after the read strobe is released
    assert_valid_after_read_R6: assert property (@(posedge clk) disable iff (rst)
        result_valid |-> (rd_n && $past(!rd_n)));

    // R7: no start while the gap timer is still running
    assert_quiet_gap_R7: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_QUIET && !tmr_zero) |=> (state_q == ST_QUIET));

    // R10: the polarity is frozen during a conversion
    assert_mode_hold_R10: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE) |=> $stable(mode_q));

endmodule

// File: tb/adc_rd_ctrl_tb_top.sv
`timescale 1ns/1ps
module adc_rd_ctrl_tb_top;
    localparam int DW    = 14;
    localparam int S_CYC = 2;
    localparam int R_CYC = 3;
    localparam int Q_CYC = 4;   // 20000 ps / 5000 ps
    localparam int LAT   = 5;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          trigger = 1'b0;
    logic          free_run = 1'b0;
    logic          mode_in = 1'b0;
    logic          busy_eoc = 1'b1;
    logic [DW-1:0] data_in = '0;
    logic          convst, cs_n, rd_n, result_valid;
    logic [DW-1:0] result;

    int checks = 0;
    int failures = 0;
    int cyc = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    adc_rd_ctrl #(
        .DATA_W(DW), .START_CYC(S_CYC), .RD_CYC(R_CYC),
        .CLK_PERIOD_PS(5000), .QUIET_PS(20000)
    ) dut_i (
        .clk(clk), .rst(rst), .trigger(trigger), .free_run(free_run),
        .mode_busy(mode_in), .busy_eoc(busy_eoc), .data_in(data_in),
        .convst(convst), .cs_n(cs_n), .rd_n(rd_n),
        .result(result), .result_valid(result_valid)
    );

    // Behavioural reference: phase 0 idle, 1 start, 2 wait, 3 read, 4 gap
    int            ph = 0;
    int            left = 0;
    bit            seen = 0;
    bit            m_mode = 0;
    bit            exp_vld = 0;
    logic [DW-1:0] exp_res = '0;

    always @(posedge clk) begin
        if (rst) begin
            ph = 0; seen = 0; m_mode = 0; exp_vld = 0; exp_res = '0;
        end else begin
            exp_vld = 0;
            case (ph)
                0: begin
                    m_mode = mode_in;
                    if (trigger || free_run) begin ph = 1; left = S_CYC; end
                end
                1: begin
                    left--;
                    if (left == 0) begin ph = 2; seen = 0; end
                end
                2: begin
                    if (!busy_eoc && (!m_mode || seen)) begin
                        ph = 3; left = R_CYC;
                    end else if (busy_eoc) begin
                        seen = 1;
                    end
                end
                3: begin
                    left--;
                    if (left == 0) begin
                        exp_res = data_in; exp_vld = 1; ph = 4; left = Q_CYC;
                    end
                end
                default: begin
                    left--;
                    if (left == 0) begin
                        if (free_run) begin ph = 1; left = S_CYC; end
                        else ph = 0;
                    end
                end
            endcase
        end
    end

    // Converter model, driven away from the active edge
    bit            conv_prev = 1;
    bit            adc_run = 0;
    int            adc_cnt = 0;
    logic [DW-1:0] next_word = 14'h01A5;

    always @(negedge clk) begin
        if (rst) begin
            busy_eoc = 1; adc_run = 0; conv_prev = 1;
        end else begin
            if (convst && !conv_prev) begin
                adc_run = 1; adc_cnt = LAT;
                if (m_mode) busy_eoc = 1;
            end else if (adc_run) begin
                adc_cnt--;
                if (adc_cnt == 0) begin
                    adc_run = 0; busy_eoc = 0;
                    data_in = next_word;
                    next_word = next_word + 14'h00BD;
                end
            end else if (!m_mode && !busy_eoc) begin
                busy_eoc = 1;
            end
            conv_prev = convst;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s cycle %0d actual=%0h expected=%0h", tag, cyc, act, exp);
        end
    endtask

    // Compare the design with the reference every cycle
    always @(negedge clk) begin
        if (!rst && !finished) begin
            if (m_mode) chk("R2 R9 R10 convst", convst, (ph == 1));
            else        chk("R1 R7 R8 convst", convst, (ph != 1));
            chk("R3 R4 cs_n", cs_n, (ph != 3));
            chk("R3 R4 rd_n", rd_n, (ph != 3));
            chk("R5 result", result, exp_res);
            chk("R6 result_valid", result_valid, exp_vld);
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000 && !finished) begin
            finished = 1;
            failures++;
            $display("FAIL watchdog cycle %0d actual=running expected=done", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic idle_cycles(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); #1;
        end
    endtask

    task automatic pulse_trigger();
        @(negedge clk); #1 trigger = 1;
        @(negedge clk); #1 trigger = 0;
    endtask

    initial begin
        idle_cycles(4);
        // R11: reset levels
        chk("R11 convst", convst, 1);
        chk("R11 cs_n", cs_n, 1);
        chk("R11 rd_n", rd_n, 1);
        chk("R11 result", result, 0);
        chk("R11 result_valid", result_valid, 0);
        rst = 0;
        idle_cycles(3);
        // R1: strobe polarity, single triggers
        pulse_trigger();
        idle_cycles(25);
        // R9: a trigger during the conversion is ignored
        pulse_trigger();
        idle_cycles(4);
        pulse_trigger();
        idle_cycles(25);
        // R2: busy polarity
        mode_in = 1;
        idle_cycles(2);
        pulse_trigger();
        // R10: polarity change mid-conversion is ignored
        idle_cycles(3);
        mode_in = 0;
        idle_cycles(25);
        mode_in = 1;
        idle_cycles(2);
        pulse_trigger();
        idle_cycles(25);
        // R8: free run in busy polarity, then in strobe polarity
        free_run = 1;
        idle_cycles(70);
        free_run = 0;
        idle_cycles(25);
        mode_in = 0;
        idle_cycles(2);
        free_run = 1;
        idle_cycles(70);
        free_run = 0;
        idle_cycles(25);
        finished = 1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule